// File: doc/BRIEF.md
# Two-Operand Integer ALU

This block is a purely combinational arithmetic logic unit for a simple load/store processor datapath. It takes two operands and a three-bit operation code. It returns a result word, the carry leaving the top bit of its adder, and a flag that is high when the result word is all zeros. Every operation is available in the same cycle that its inputs settle. The block holds no state and has no clock.

The datapath repeats one bit slice per operand bit. Each slice holds a gate pair for AND and OR, a full adder, and a four-way select. A shared carry network joins the slices. It is built either as a plain ripple chain or as a grouped lookahead chain, chosen by a parameter. Subtraction uses the adder: the top bit of the operation code inverts the second operand and feeds a carry of one into bit 0. The set-if-less operation reuses that difference and routes its sign bit to result bit 0. The all-zero flag lets a branch unit test two registers for equality by requesting a subtraction.

Top module: `alu_core`

## Requirements
- R1: Code 3'b000 gives result = a AND b, bit by bit.
- R2: Code 3'b001 gives result = a OR b, bit by bit.
- R3: Code 3'b010 gives result = (a + b) mod 2^WIDTH, and carry_out is the carry out of the top bit of that sum.
- R4: Code 3'b110 gives result = (a - b) mod 2^WIDTH, formed as a + NOT b + 1. carry_out is the carry out of the top bit of that sum, so it is 1 exactly when a >= b as unsigned numbers.
- R5: Code 3'b111 gives result bit 0 equal to the top bit of (a - b) mod 2^WIDTH, with all other result bits 0. There is no overflow correction, so a = 32'h7FFF_FFFF with b = 32'hFFFF_FFFF yields 1.
- R6: For every code, zero is 1 exactly when all result bits are 0.
- R7: With code 3'b110, zero is 1 exactly when a equals b.
- R8: Codes 3'b011, 3'b100 and 3'b101 give a result of all zeros, and therefore zero = 1, whatever the operands are.
- R9: The outputs depend only on the present inputs. A new operand or code is reflected within the same cycle, with no trace of earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand (the subtrahend for subtract and compare) |
| op_code | input | 3 | Operation select. Bit 2 inverts b and sets the carry-in; bits 1:0 pick the output source |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry out of the adder's top bit, meaningful for add and subtract |
| zero | output | 1 | High when result is all zeros |

## Verification
The block is combinational, so every output is due in the same cycle its inputs are applied. The driver applies the operands and the code just after a rising edge and pushes the model's expected values into a queue. The monitor pops one item at the following falling edge, half a period later, after all carry paths have settled. Because exactly one stimulus is applied per cycle and nothing is retained, a value still visible from the previous vector would show up as a mismatch. This covers R9.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [2:0] {
      ALU_AND = 3'b000,
      ALU_OR  = 3'b001,
      ALU_ADD = 3'b010,
      ALU_SUB = 3'b110,
      ALU_SLT = 3'b111
   } alu_op_e;

   typedef enum logic [1:0] {
      SRC_AND  = 2'b00,
      SRC_OR   = 2'b01,
      SRC_SUM  = 2'b10,
      SRC_LESS = 2'b11
   } slice_src_e;

   function automatic logic op_known(input logic [2:0] code);
      case (code)
         ALU_AND, ALU_OR, ALU_ADD, ALU_SUB, ALU_SLT: op_known = 1'b1;
         default:                                    op_known = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
   import alu_pkg::*;
(
   input  logic       a_bit,
   input  logic       b_bit,
   input  logic       b_invert,
   input  logic       carry_in,
   input  logic       less_in,
   input  logic [1:0] src_sel,
   output logic       b_eff,
   output logic       sum_bit,
   output logic       res_bit
);

   logic and_v;
   logic or_v;

   assign b_eff   = b_bit ^ b_invert;
   assign and_v   = a_bit & b_eff;
   assign or_v    = a_bit | b_eff;
   assign sum_bit = a_bit ^ b_eff ^ carry_in;

   always_comb begin
      case (slice_src_e'(src_sel))
         SRC_AND:  res_bit = and_v;
         SRC_OR:   res_bit = or_v;
         SRC_SUM:  res_bit = sum_bit;
         default:  res_bit = less_in;
      endcase
   end

endmodule

// File: rtl/alu_carry_net.sv
module alu_carry_net #(
   parameter int unsigned WIDTH     = 32,
   parameter bit          LOOKAHEAD = 1'b1,
   parameter int unsigned GROUP     = 4
) (
   input  logic [WIDTH-1:0] a_vec,
   input  logic [WIDTH-1:0] b_vec,
   input  logic             c_in,
   output logic [WIDTH:0]   carries
);

   localparam int unsigned NGRP = (WIDTH + GROUP - 1) / GROUP;

   logic [WIDTH-1:0] gen;
   logic [WIDTH-1:0] prop;

   assign gen  = a_vec & b_vec;
   assign prop = a_vec | b_vec;

   if (WIDTH < 2) begin : g_bad_width
      $error("alu_carry_net: WIDTH must be at least 2");
   end

   if (LOOKAHEAD) begin : g_lookahead
      if (GROUP < 2) begin : g_bad_group
         $error("alu_carry_net: GROUP must be at least 2");
      end
      if ((WIDTH % GROUP) != 0) begin : g_bad_split
         $error("alu_carry_net: WIDTH must be a multiple of GROUP");
      end

      logic [NGRP-1:0] grp_g;
      logic [NGRP-1:0] grp_p;
      logic [NGRP:0]   grp_c;

      // group generate/propagate, built without reference to any carry
      always_comb begin
         for (int k = 0; k < int'(NGRP); k++) begin
            logic gg;
            logic pp;
            gg = 1'b0;
            pp = 1'b1;
            for (int j = 0; j < int'(GROUP); j++) begin
               gg = gen[k*GROUP+j] | (prop[k*GROUP+j] & gg);
               pp = pp & prop[k*GROUP+j];
            end
            grp_g[k] = gg;
            grp_p[k] = pp;
         end
      end

      // carry between groups skips whole groups
      always_comb begin
         grp_c[0] = c_in;
         for (int k = 0; k < int'(NGRP); k++) begin
            grp_c[k+1] = grp_g[k] | (grp_p[k] & grp_c[k]);
         end
      end

      // carries inside a group start from the group carry-in
      always_comb begin
         carries = '0;
         for (int k = 0; k < int'(NGRP); k++) begin
            logic cc;
            cc = grp_c[k];
            carries[k*GROUP] = cc;
            for (int j = 0; j < int'(GROUP); j++) begin
               cc = gen[k*GROUP+j] | (prop[k*GROUP+j] & cc);
               if (j < int'(GROUP) - 1) carries[k*GROUP+j+1] = cc;
            end
         end
         carries[WIDTH] = grp_c[NGRP];
      end
   end else begin : g_ripple
      always_comb begin
         carries[0] = c_in;
         for (int i = 0; i < int'(WIDTH); i++) begin
            carries[i+1] = gen[i] | (prop[i] & carries[i]);
         end
      end
   end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] word,
   output logic             is_zero
);

   localparam int unsigned HALF = WIDTH / 2;

   logic any_lo;
   logic any_hi;

   if (WIDTH < 2) begin : g_bad
      $error("alu_zero_detect: WIDTH must be at least 2");
   end

   // two balanced halves keep the OR tree shallow
   assign any_lo  = |word[HALF-1:0];
   assign any_hi  = |word[WIDTH-1:HALF];
   assign is_zero = ~(any_lo | any_hi);

endmodule

// File: rtl/alu_core.sv
module alu_core
   import alu_pkg::*;
#(
   parameter int unsigned WIDTH     = 32,
   parameter bit          LOOKAHEAD = 1'b1,
   parameter int unsigned GROUP     = 4
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [2:0]       op_code,
   output logic [WIDTH-1:0] result,
   output logic             carry_out,
   output logic             zero
);

   localparam int unsigned MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("alu_core: WIDTH must be at least 2");
   end

   logic             b_inv;
   logic [1:0]       src;
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] sums;
   logic [WIDTH-1:0] raw;
   logic [WIDTH-1:0] less_vec;
   logic [WIDTH:0]   carries;
   logic             known;

   assign b_inv = op_code[2];
   assign src   = op_code[1:0];
   assign known = op_known(op_code);

   // only bit 0 receives the sign of the difference
   assign less_vec = {{(WIDTH-1){1'b0}}, sums[MSB]};

   for (genvar i = 0; i < int'(WIDTH); i++) begin : g_slice
      alu_bit_slice u_slice (
         .a_bit    (opnd_a[i]),
         .b_bit    (opnd_b[i]),
         .b_invert (b_inv),
         .carry_in (carries[i]),
         .less_in  (less_vec[i]),
         .src_sel  (src),
         .b_eff    (b_eff[i]),
         .sum_bit  (sums[i]),
         .res_bit  (raw[i])
      );
   end

   alu_carry_net #(
      .WIDTH     (WIDTH),
      .LOOKAHEAD (LOOKAHEAD),
      .GROUP     (GROUP)
   ) u_carry (
      .a_vec   (opnd_a),
      .b_vec   (b_eff),
      .c_in    (b_inv),
      .carries (carries)
   );

   assign result    = known ? raw : '0;
   assign carry_out = carries[WIDTH];

   alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
      .word    (result),
      .is_zero (zero)
   );

   always_comb begin
      if (!$isunknown({opnd_a, opnd_b, op_code})) begin
         if (op_code == ALU_AND)
            p_and_r1: assert (result == (opnd_a & opnd_b));
         if (op_code == ALU_OR)
            p_or_r2: assert (result == (opnd_a | opnd_b));
         if (op_code == ALU_ADD)
            p_add_r3: assert ({carry_out, result} == ({1'b0, opnd_a} + {1'b0, opnd_b}));
         if (op_code == ALU_SUB)
            p_sub_r4: assert ((result == opnd_a - opnd_b) && (carry_out == (opnd_a >= opnd_b)));
         if (op_code == ALU_SLT)
            p_slt_upper_r5: assert (result[MSB:1] == '0);
         if (op_code == ALU_SUB)
            p_equal_r7: assert (zero == (opnd_a == opnd_b));
         if (!op_known(op_code))
            p_unlisted_r8: assert (result == '0 && zero);
      end
   end

endmodule

// File: tb/alu_core_test.sv
module alu_core_test;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic [2:0]   op = 3'b000;
   logic [W-1:0] result;
   logic         carry_out;
   logic         zero;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   typedef struct {
      logic [W-1:0] res;
      logic         cy;
      logic         cy_valid;
      logic         z;
      string        tag;
   } exp_t;

   exp_t sb[$];

   always #10 clk = ~clk;   // 50 MHz

   alu_core uut (
      .opnd_a    (opnd_a_w),
      .opnd_b    (opnd_b_w),
      .op_code   (op),
      .result    (result),
      .carry_out (carry_out),
      .zero      (zero)
   );

   wire [W-1:0] opnd_a_w = a;
   wire [W-1:0] opnd_b_w = b;

   function automatic exp_t model(input logic [2:0] c, input logic [W-1:0] x,
                                  input logic [W-1:0] y, input string tag);
      exp_t e;
      logic [W:0] wide;
      e.tag = tag;
      e.cy = 1'b0;
      e.cy_valid = 1'b0;
      case (c)
         3'b000: e.res = x & y;
         3'b001: e.res = x | y;
         3'b010: begin
            wide = {1'b0, x} + {1'b0, y};
            e.res = wide[W-1:0];
            e.cy = wide[W];
            e.cy_valid = 1'b1;
         end
         3'b110: begin
            e.res = x - y;
            e.cy = (x >= y);
            e.cy_valid = 1'b1;
         end
         3'b111: begin
            logic [W-1:0] d;
            d = x - y;
            e.res = {{(W-1){1'b0}}, d[W-1]};
         end
         default: e.res = '0;
      endcase
      e.z = (e.res == '0);
      return e;
   endfunction

   task automatic drive(input logic [2:0] c, input logic [W-1:0] x,
                        input logic [W-1:0] y, input string tag);
      @(posedge clk);
      #1;
      a = x;
      b = y;
      op = c;
      sb.push_back(model(c, x, y, tag));
   endtask

   // monitor: one item per cycle, sampled at the falling edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (result !== e.res || zero !== e.z || (e.cy_valid && carry_out !== e.cy)) begin
            errors++;
            $display("FAIL %s: op=%b a=%h b=%h result=%h zero=%b cout=%b expected result=%h zero=%b cout=%b",
                     e.tag, op, a, b, result, zero, carry_out, e.res, e.z, e.cy);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         errors++;
         $display("FAIL watchdog: cycles=%0d expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      // reset state: zero inputs give AND of zeros (R6)
      drive(3'b000, 32'h0, 32'h0, "R6 idle");
      drive(3'b000, 32'hF0F0_A5A5, 32'h0FF0_FF00, "R1 and");
      drive(3'b000, 32'hFFFF_FFFF, 32'h1234_5678, "R1 and ones");
      drive(3'b001, 32'hF000_0001, 32'h0F00_0010, "R2 or");
      drive(3'b001, 32'h0, 32'h0, "R2 R6 or zero");
      drive(3'b010, 32'h0000_0005, 32'h0000_0007, "R3 add");
      drive(3'b010, 32'hFFFF_FFFF, 32'h0000_0001, "R3 R6 add wrap carry");
      drive(3'b010, 32'h8000_0000, 32'h8000_0000, "R3 add top carry");
      drive(3'b010, 32'h0000_FFFF, 32'h0000_0001, "R3 add group carry");
      drive(3'b110, 32'h0000_0009, 32'h0000_0004, "R4 sub");
      drive(3'b110, 32'h0000_0003, 32'h0000_0008, "R4 sub borrow");
      drive(3'b110, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R7 sub equal");
      drive(3'b110, 32'hDEAD_BEEF, 32'hDEAD_BEEE, "R7 sub unequal");
      drive(3'b111, 32'hFFFF_FFFE, 32'h0000_0001, "R5 slt neg");
      drive(3'b111, 32'h0000_0005, 32'h0000_0002, "R5 slt pos");
      drive(3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R5 slt no overflow fix");
      drive(3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8 code 011");
      drive(3'b100, 32'hFFFF_FFFF, 32'h0000_0000, "R8 code 100");
      drive(3'b101, 32'hAAAA_AAAA, 32'h5555_5555, "R8 code 101");
      // R9: back-to-back vectors, each must reflect only its own inputs
      drive(3'b001, 32'hFFFF_FFFF, 32'h0, "R9 ones");
      drive(3'b000, 32'h0, 32'hFFFF_FFFF, "R9 then zero");
      lfsr = 32'hACE1_1234;
      for (int n = 0; n < 400; n++) begin
         logic [W-1:0] x;
         logic [W-1:0] y;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         x = lfsr * 32'h9E37_79B9;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         y = (n % 7 == 0) ? x : lfsr ^ 32'h5BD1_E995;
         drive(lfsr[2:0] ^ 3'(n), x, y, "R1 R2 R3 R4 R5 R6 R7 R8 sweep");
      end
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule